// File: doc/BRIEF.md
# Multi-Device Expansion Card Configuration Register File

This block is the configuration register file of a plug-in expansion card that carries several logical devices. The host reaches it through an index/data port. A write on the index path picks an 8-bit register offset. A write on the data path stores a byte at that offset, and the read data shows the byte held there. The block tracks a card-level state: wait-for-key, sleep or configuration. A wake command whose data byte equals the card's select number moves the card into configuration. A wake command with any other byte moves it into sleep.

A device-number register chooses which logical device's bank the offsets reach. Each bank holds the following:
- memory descriptors, each with a base, a control field and a limit;
- I/O base descriptors;
- interrupt level and trigger-type selects;
- DMA channel selects;
- an activate bit.

Interrupt level 0 means "no interrupt assigned", and DMA select 4 means "no channel assigned". Chosen devices can have their first I/O descriptor hard-wired, in which case it is read-only. Every device's settings are exported on flat output buses. A device's outputs show its programmed resources only while its activate bit is set.

Top module: `mfcard_cfg`

## Requirements
- R1: After reset the card is in wait-for-key, the device number is 0 and every activate bit is clear. In every bank, bases, limits and control fields are 0, interrupt selects are 0 and DMA selects are 4.
- R2: `keyUnlock` moves wait-for-key to sleep. In sleep or configuration, a `wakeCmd` with `wrData` equal to `cardCsn` enters configuration, and any other byte enters sleep. `wakeCmd` is ignored in wait-for-key. `returnWfk` forces wait-for-key and has the highest priority.
- R3: Outside the configuration state, data writes change nothing and `rdData` reads 0.
- R4: Offset 0x07 holds the device number and reads back its value. A write of a value not below NUM_DEV is ignored. All other offsets reach the bank of the selected device.
- R5: Memory descriptor m (m < NUM_MEM) sits at 0x40+8m. It holds the base high byte, then the base low byte, then a control byte that stores bits [1:0] only, then the limit high byte, then the limit low byte.
- R6: I/O descriptor i (i < NUM_IO) has its high byte at 0x60+2i and its low byte at 0x61+2i.
- R7: Interrupt slot n (n < NUM_IRQ) keeps its level in bits [3:0] at 0x70+2n and its type in bits [1:0] at 0x71+2n. A level write whose bits [3:0] equal 2 is ignored. A level of 9 is stored as 9.
- R8: DMA slot n (n < NUM_DMA) sits at 0x74+n and stores bits [2:0]. A write whose bits [2:0] exceed 4 is ignored.
- R9: For each device whose bit in FIXED_IO_MASK is set, I/O descriptor 0 always reads FIXED_IO_BASE and ignores writes.
- R10: The activate bit is bit 0 of offset 0x30. While a device is inactive, its exported bases, limits, controls, interrupt levels and types are 0 and its DMA selects are 4. While it is active, the exports equal its register values.
- R11: Unimplemented offsets read 0, and so do the unused upper bits of narrow fields. This covers descriptor slots at or above the configured counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cardCsn | input | 8 | This card's select number |
| keyUnlock | input | 1 | Key sequence seen: leave wait-for-key |
| returnWfk | input | 1 | Return to wait-for-key |
| wakeCmd | input | 1 | Wake command, data byte on wrData |
| idxWr | input | 1 | Load register offset from wrData |
| dataWr | input | 1 | Write wrData to the selected offset |
| wrData | input | 8 | Write byte |
| rdData | output | 8 | Byte at the current offset |
| devActive | output | NUM_DEV | Activate bit per device |
| memBaseOut | output | NUM_DEV*NUM_MEM*16 | Gated memory bases |
| memCtrlOut | output | NUM_DEV*NUM_MEM*2 | Gated memory control fields |
| memLimitOut | output | NUM_DEV*NUM_MEM*16 | Gated memory limits |
| ioBaseOut | output | NUM_DEV*NUM_IO*16 | Gated I/O bases |
| irqLevelOut | output | NUM_DEV*NUM_IRQ*4 | Gated interrupt levels |
| irqTypeOut | output | NUM_DEV*NUM_IRQ*2 | Gated interrupt types |
| dmaSelOut | output | NUM_DEV*NUM_DMA*3 | Gated DMA selects (4 = none) |

## Verification
The bench reads all 128 offsets of both banks after reset and again after a full write sweep. A wrong field decode would therefore show up as a stray byte at an unimplemented offset, or as bank 1 echoing bank 0. Every interrupt level 0 to 15 and every DMA code 0 to 7 is written. This exposes a design that stores the invalid level 2 or an out-of-range channel, and one that drops level 9. The state sequence is driven through a wake in wait-for-key, a mismatching wake and a return to wait-for-key, where a leaky write gate would change the activate bits. The exports are compared with active and inactive devices, including the hard-wired I/O descriptor, so that missing gating or a fixed value leaking while inactive is caught.

// File: rtl/mfcard_cfg_pkg.sv
package mfcard_cfg_pkg;

  typedef enum logic [1:0] {
    ST_WFK   = 2'd0,
    ST_SLEEP = 2'd1,
    ST_CFG   = 2'd2
  } cardState_e;

  localparam logic [7:0] OFS_LDN = 8'h07;
  localparam logic [7:0] OFS_ACT = 8'h30;

  typedef enum logic [3:0] {
    F_NONE, F_ACT,
    F_MEMBH, F_MEMBL, F_MEMCTL, F_MEMLH, F_MEMLL,
    F_IOH, F_IOL,
    F_IRQL, F_IRQT,
    F_DMA
  } field_e;

  typedef struct packed {
    field_e     field;
    logic [2:0] slot;
  } fieldSel_t;

  // write strobes from control to datapath
  typedef struct packed {
    logic       we;
    field_e     field;
    logic [2:0] slot;
    logic [7:0] data;
  } regStrobe_t;

  function automatic fieldSel_t decodeIdx(input logic [7:0] idx, input int nMem,
                                          input int nIo, input int nIrq, input int nDma);
    fieldSel_t r;
    r.field = F_NONE;
    r.slot  = 3'd0;
    if (idx == OFS_ACT) begin
      r.field = F_ACT;
    end else if (idx[7:5] == 3'b010) begin
      if (int'(idx[4:3]) < nMem) begin
        r.slot = {1'b0, idx[4:3]};
        case (idx[2:0])
          3'd0:    r.field = F_MEMBH;
          3'd1:    r.field = F_MEMBL;
          3'd2:    r.field = F_MEMCTL;
          3'd3:    r.field = F_MEMLH;
          3'd4:    r.field = F_MEMLL;
          default: r.field = F_NONE;
        endcase
      end
    end else if (idx[7:4] == 4'h6) begin
      if (int'(idx[3:1]) < nIo) begin
        r.slot  = idx[3:1];
        r.field = idx[0] ? F_IOL : F_IOH;
      end
    end else if (idx[7:2] == 6'b011100) begin
      if (int'(idx[1]) < nIrq) begin
        r.slot  = {2'b00, idx[1]};
        r.field = idx[0] ? F_IRQT : F_IRQL;
      end
    end else if (idx[7:1] == 7'b0111010) begin
      if (int'(idx[0]) < nDma) begin
        r.slot  = {2'b00, idx[0]};
        r.field = F_DMA;
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/mfcard_cfg_ctrl.sv
module mfcard_cfg_ctrl
  import mfcard_cfg_pkg::*;
#(
  parameter int NUM_DEV = 2,
  parameter int NUM_MEM = 2,
  parameter int NUM_IO  = 2,
  parameter int NUM_IRQ = 2,
  parameter int NUM_DMA = 2,
  parameter int LDN_W   = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       cardCsn,
  input  logic             keyUnlock,
  input  logic             returnWfk,
  input  logic             wakeCmd,
  input  logic             idxWr,
  input  logic             dataWr,
  input  logic [7:0]       wrData,
  output regStrobe_t       strobe,
  output fieldSel_t        rdSel,
  output logic [LDN_W-1:0] curDev,
  output logic             ldnSel,
  output logic             inCfg,
  output cardState_e       cardState
);

  cardState_e       stQ;
  logic [7:0]       idxQ;
  logic [LDN_W-1:0] devQ;
  fieldSel_t        sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stQ <= ST_WFK;
    end else if (returnWfk) begin
      stQ <= ST_WFK;
    end else if (wakeCmd && stQ != ST_WFK) begin
      stQ <= (wrData == cardCsn) ? ST_CFG : ST_SLEEP;
    end else if (keyUnlock && stQ == ST_WFK) begin
      stQ <= ST_SLEEP;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idxQ <= 8'h00;
    else if (idxWr) idxQ <= wrData;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      devQ <= '0;
    end else if (dataWr && stQ == ST_CFG && idxQ == OFS_LDN && int'(wrData) < NUM_DEV) begin
      devQ <= wrData[LDN_W-1:0];
    end
  end

  always_comb begin
    sel          = decodeIdx(idxQ, NUM_MEM, NUM_IO, NUM_IRQ, NUM_DMA);
    strobe.we    = dataWr && (stQ == ST_CFG) && (sel.field != F_NONE);
    strobe.field = sel.field;
    strobe.slot  = sel.slot;
    strobe.data  = wrData;
  end

  assign rdSel     = sel;
  assign curDev    = devQ;
  assign ldnSel    = (idxQ == OFS_LDN);
  assign inCfg     = (stQ == ST_CFG);
  assign cardState = stQ;

endmodule

// File: rtl/mfcard_cfg_dp.sv
module mfcard_cfg_dp
  import mfcard_cfg_pkg::*;
#(
  parameter int              NUM_DEV       = 2,
  parameter int              NUM_MEM       = 2,
  parameter int              NUM_IO        = 2,
  parameter int              NUM_IRQ       = 2,
  parameter int              NUM_DMA       = 2,
  parameter logic [NUM_DEV-1:0] FIXED_IO_MASK = '0,
  parameter logic [15:0]     FIXED_IO_BASE = 16'h0000,
  parameter int              LDN_W         = 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  regStrobe_t                    strobe,
  input  fieldSel_t                     rdSel,
  input  logic [LDN_W-1:0]              curDev,
  output logic [7:0]                    rdData,
  output logic [NUM_DEV-1:0]            devActive,
  output logic [NUM_DEV*NUM_MEM*16-1:0] memBaseOut,
  output logic [NUM_DEV*NUM_MEM*2-1:0]  memCtrlOut,
  output logic [NUM_DEV*NUM_MEM*16-1:0] memLimitOut,
  output logic [NUM_DEV*NUM_IO*16-1:0]  ioBaseOut,
  output logic [NUM_DEV*NUM_IRQ*4-1:0]  irqLevelOut,
  output logic [NUM_DEV*NUM_IRQ*2-1:0]  irqTypeOut,
  output logic [NUM_DEV*NUM_DMA*3-1:0]  dmaSelOut
);

  localparam logic [2:0] DMA_NONE = 3'd4;
  localparam logic [3:0] IRQ_BAD  = 4'd2;

  logic [7:0] devRd [NUM_DEV];

  for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
    localparam bit IS_FIXED = FIXED_IO_MASK[d];

    logic        devHit;
    logic        actQ;
    logic [15:0] memBaseQ [NUM_MEM];
    logic [1:0]  memCtrlQ [NUM_MEM];
    logic [15:0] memLimQ  [NUM_MEM];
    logic [15:0] ioQ      [NUM_IO];
    logic [15:0] ioView   [NUM_IO];
    logic [3:0]  irqLvlQ  [NUM_IRQ];
    logic [1:0]  irqTypQ  [NUM_IRQ];
    logic [2:0]  dmaQ     [NUM_DMA];
    logic [7:0]  rdQ;

    assign devHit = strobe.we && (curDev == LDN_W'(d));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        actQ <= 1'b0;
        for (int s = 0; s < NUM_MEM; s++) begin
          memBaseQ[s] <= '0;
          memCtrlQ[s] <= '0;
          memLimQ[s]  <= '0;
        end
        for (int s = 0; s < NUM_IO; s++)  ioQ[s] <= '0;
        for (int s = 0; s < NUM_IRQ; s++) begin
          irqLvlQ[s] <= '0;
          irqTypQ[s] <= '0;
        end
        for (int s = 0; s < NUM_DMA; s++) dmaQ[s] <= DMA_NONE;
      end else if (devHit) begin
        if (strobe.field == F_ACT) actQ <= strobe.data[0];
        for (int s = 0; s < NUM_MEM; s++) begin
          if (strobe.slot == 3'(s)) begin
            case (strobe.field)
              F_MEMBH:  memBaseQ[s][15:8] <= strobe.data;
              F_MEMBL:  memBaseQ[s][7:0]  <= strobe.data;
              F_MEMCTL: memCtrlQ[s]       <= strobe.data[1:0];
              F_MEMLH:  memLimQ[s][15:8]  <= strobe.data;
              F_MEMLL:  memLimQ[s][7:0]   <= strobe.data;
              default: ;
            endcase
          end
        end
        for (int s = 0; s < NUM_IO; s++) begin
          if (strobe.slot == 3'(s) && !(IS_FIXED && s == 0)) begin
            if (strobe.field == F_IOH) ioQ[s][15:8] <= strobe.data;
            if (strobe.field == F_IOL) ioQ[s][7:0]  <= strobe.data;
          end
        end
        for (int s = 0; s < NUM_IRQ; s++) begin
          if (strobe.slot == 3'(s)) begin
            if (strobe.field == F_IRQL && strobe.data[3:0] != IRQ_BAD) irqLvlQ[s] <= strobe.data[3:0];
            if (strobe.field == F_IRQT) irqTypQ[s] <= strobe.data[1:0];
          end
        end
        for (int s = 0; s < NUM_DMA; s++) begin
          if (strobe.slot == 3'(s) && strobe.field == F_DMA && strobe.data[2:0] <= DMA_NONE)
            dmaQ[s] <= strobe.data[2:0];
        end
      end
    end

    for (genvar s = 0; s < NUM_IO; s++) begin : g_ioView
      if (IS_FIXED && s == 0) begin : g_fixed
        assign ioView[s] = FIXED_IO_BASE;
      end else begin : g_prog
        assign ioView[s] = ioQ[s];
      end
    end

    always_comb begin
      rdQ = 8'h00;
      if (rdSel.field == F_ACT) rdQ = {7'b0, actQ};
      for (int s = 0; s < NUM_MEM; s++) begin
        if (rdSel.slot == 3'(s)) begin
          case (rdSel.field)
            F_MEMBH:  rdQ = memBaseQ[s][15:8];
            F_MEMBL:  rdQ = memBaseQ[s][7:0];
            F_MEMCTL: rdQ = {6'b0, memCtrlQ[s]};
            F_MEMLH:  rdQ = memLimQ[s][15:8];
            F_MEMLL:  rdQ = memLimQ[s][7:0];
            default: ;
          endcase
        end
      end
      for (int s = 0; s < NUM_IO; s++) begin
        if (rdSel.slot == 3'(s)) begin
          if (rdSel.field == F_IOH) rdQ = ioView[s][15:8];
          if (rdSel.field == F_IOL) rdQ = ioView[s][7:0];
        end
      end
      for (int s = 0; s < NUM_IRQ; s++) begin
        if (rdSel.slot == 3'(s)) begin
          if (rdSel.field == F_IRQL) rdQ = {4'b0, irqLvlQ[s]};
          if (rdSel.field == F_IRQT) rdQ = {6'b0, irqTypQ[s]};
        end
      end
      for (int s = 0; s < NUM_DMA; s++) begin
        if (rdSel.slot == 3'(s) && rdSel.field == F_DMA) rdQ = {5'b0, dmaQ[s]};
      end
    end

    assign devRd[d]     = rdQ;
    assign devActive[d] = actQ;

    for (genvar s = 0; s < NUM_MEM; s++) begin : g_memOut
      assign memBaseOut[(d*NUM_MEM+s)*16 +: 16] = actQ ? memBaseQ[s] : 16'h0000;
      assign memCtrlOut[(d*NUM_MEM+s)*2 +: 2]   = actQ ? memCtrlQ[s] : 2'b00;
      assign memLimitOut[(d*NUM_MEM+s)*16 +: 16] = actQ ? memLimQ[s] : 16'h0000;
    end
    for (genvar s = 0; s < NUM_IO; s++) begin : g_ioOut
      assign ioBaseOut[(d*NUM_IO+s)*16 +: 16] = actQ ? ioView[s] : 16'h0000;
    end
    for (genvar s = 0; s < NUM_IRQ; s++) begin : g_irqOut
      assign irqLevelOut[(d*NUM_IRQ+s)*4 +: 4] = actQ ? irqLvlQ[s] : 4'd0;
      assign irqTypeOut[(d*NUM_IRQ+s)*2 +: 2]  = actQ ? irqTypQ[s] : 2'd0;
    end
    for (genvar s = 0; s < NUM_DMA; s++) begin : g_dmaOut
      assign dmaSelOut[(d*NUM_DMA+s)*3 +: 3] = actQ ? dmaQ[s] : DMA_NONE;
    end
  end

  always_comb begin
    rdData = 8'h00;
    for (int d = 0; d < NUM_DEV; d++) begin
      if (curDev == LDN_W'(d)) rdData = devRd[d];
    end
  end

endmodule

// File: rtl/mfcard_cfg.sv
module mfcard_cfg
  import mfcard_cfg_pkg::*;
#(
  parameter int              NUM_DEV       = 2,
  parameter int              NUM_MEM       = 2,
  parameter int              NUM_IO        = 2,
  parameter int              NUM_IRQ       = 2,
  parameter int              NUM_DMA       = 2,
  parameter logic [NUM_DEV-1:0] FIXED_IO_MASK = 2'b10,
  parameter logic [15:0]     FIXED_IO_BASE = 16'h0220,
  localparam int             LDN_W         = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1,
  localparam int             MEM_W         = NUM_DEV * NUM_MEM,
  localparam int             IO_W          = NUM_DEV * NUM_IO,
  localparam int             IRQ_W         = NUM_DEV * NUM_IRQ,
  localparam int             DMA_W         = NUM_DEV * NUM_DMA
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [7:0]           cardCsn,
  input  logic                 keyUnlock,
  input  logic                 returnWfk,
  input  logic                 wakeCmd,
  input  logic                 idxWr,
  input  logic                 dataWr,
  input  logic [7:0]           wrData,
  output logic [7:0]           rdData,
  output logic [NUM_DEV-1:0]   devActive,
  output logic [MEM_W*16-1:0]  memBaseOut,
  output logic [MEM_W*2-1:0]   memCtrlOut,
  output logic [MEM_W*16-1:0]  memLimitOut,
  output logic [IO_W*16-1:0]   ioBaseOut,
  output logic [IRQ_W*4-1:0]   irqLevelOut,
  output logic [IRQ_W*2-1:0]   irqTypeOut,
  output logic [DMA_W*3-1:0]   dmaSelOut
);

  regStrobe_t       strobe;
  fieldSel_t        rdSel;
  logic [LDN_W-1:0] curDev;
  logic             ldnSel;
  logic             inCfg;
  cardState_e       cardState;
  logic [7:0]       bankRd;

  mfcard_cfg_ctrl #(
    .NUM_DEV(NUM_DEV), .NUM_MEM(NUM_MEM), .NUM_IO(NUM_IO),
    .NUM_IRQ(NUM_IRQ), .NUM_DMA(NUM_DMA), .LDN_W(LDN_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cardCsn(cardCsn), .keyUnlock(keyUnlock),
    .returnWfk(returnWfk), .wakeCmd(wakeCmd), .idxWr(idxWr), .dataWr(dataWr),
    .wrData(wrData), .strobe(strobe), .rdSel(rdSel), .curDev(curDev),
    .ldnSel(ldnSel), .inCfg(inCfg), .cardState(cardState)
  );

  mfcard_cfg_dp #(
    .NUM_DEV(NUM_DEV), .NUM_MEM(NUM_MEM), .NUM_IO(NUM_IO),
    .NUM_IRQ(NUM_IRQ), .NUM_DMA(NUM_DMA), .FIXED_IO_MASK(FIXED_IO_MASK),
    .FIXED_IO_BASE(FIXED_IO_BASE), .LDN_W(LDN_W)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .rdSel(rdSel), .curDev(curDev),
    .rdData(bankRd), .devActive(devActive), .memBaseOut(memBaseOut),
    .memCtrlOut(memCtrlOut), .memLimitOut(memLimitOut), .ioBaseOut(ioBaseOut),
    .irqLevelOut(irqLevelOut), .irqTypeOut(irqTypeOut), .dmaSelOut(dmaSelOut)
  );

  always_comb begin
    if (!inCfg)      rdData = 8'h00;
    else if (ldnSel) rdData = 8'(curDev);
    else             rdData = bankRd;
  end

endmodule

// File: rtl/mfcard_cfg_chk.sv
module mfcard_cfg_chk
  import mfcard_cfg_pkg::*;
#(
  parameter int NUM_DEV = 2,
  parameter int NUM_IRQ = 2,
  parameter int NUM_DMA = 2
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         wakeCmd,
  input logic                         returnWfk,
  input logic [7:0]                   wrData,
  input logic [7:0]                   cardCsn,
  input cardState_e                   cardState,
  input logic                         inCfg,
  input logic [NUM_DEV-1:0]           devActive,
  input logic [NUM_DEV*NUM_IRQ*4-1:0] irqLevelOut,
  input logic [NUM_DEV*NUM_DMA*3-1:0] dmaSelOut
);

  assert_wake_miss_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wakeCmd && !returnWfk && cardState != ST_WFK && wrData != cardCsn) |=> !inCfg);

  assert_frozen_outside_cfg_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !inCfg |=> $stable(devActive));

  for (genvar g = 0; g < NUM_DEV*NUM_IRQ; g++) begin : g_irq
    assert_irq_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
      irqLevelOut[g*4 +: 4] != 4'd2);
  end

  for (genvar g = 0; g < NUM_DEV*NUM_DMA; g++) begin : g_dma
    assert_dma_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
      dmaSelOut[g*3 +: 3] <= 3'd4);
  end

  for (genvar d = 0; d < NUM_DEV; d++) begin : g_act
    assert_activate_in_cfg_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(devActive[d]) |-> $past(inCfg));
  end

endmodule

bind mfcard_cfg mfcard_cfg_chk #(
  .NUM_DEV(NUM_DEV), .NUM_IRQ(NUM_IRQ), .NUM_DMA(NUM_DMA)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wakeCmd(wakeCmd), .returnWfk(returnWfk),
  .wrData(wrData), .cardCsn(cardCsn), .cardState(cardState), .inCfg(inCfg),
  .devActive(devActive), .irqLevelOut(irqLevelOut), .dmaSelOut(dmaSelOut)
);

// File: tb/mfcard_cfg_test.sv
module mfcard_cfg_test;
  timeunit 1ns;
  timeprecision 1ps;

  localparam logic [7:0] CSN = 8'h03;
  localparam logic [15:0] FIXED = 16'h0220;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  cardCsn = CSN;
  logic        keyUnlock = 1'b0, returnWfk = 1'b0, wakeCmd = 1'b0;
  logic        idxWr = 1'b0, dataWr = 1'b0;
  logic [7:0]  wrData = 8'h00;
  logic [7:0]  rdData;
  logic [1:0]  devActive;
  logic [63:0] memBaseOut, memLimitOut, ioBaseOut;
  logic [7:0]  memCtrlOut, irqTypeOut;
  logic [15:0] irqLevelOut;
  logic [11:0] dmaSelOut;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;
  logic [7:0] sh [2][128];
  int curLdn = 0;

  always #4 clk = ~clk;

  mfcard_cfg uut (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  task automatic strobeOp(input int kind, input logic [7:0] v);
    @(negedge clk);
    wrData = v;
    case (kind)
      0: idxWr = 1'b1;
      1: dataWr = 1'b1;
      2: wakeCmd = 1'b1;
      3: keyUnlock = 1'b1;
      default: returnWfk = 1'b1;
    endcase
    @(negedge clk);
    {idxWr, dataWr, wakeCmd, keyUnlock, returnWfk} = '0;
    #1;
  endtask

  function automatic bit isFixed(input int d);
    return d == 1;
  endfunction

  // expected read value from the requirements
  function automatic logic [7:0] modelRead(input int d, input int off);
    if (off == 8'h07) return 8'(curLdn);
    if (off == 8'h30) return {7'b0, sh[d][off][0]};
    if (off >= 8'h40 && off < 8'h60) begin
      if ((off - 64) / 8 < 2 && (off % 8) <= 4)
        return ((off % 8) == 2) ? (sh[d][off] & 8'h03) : sh[d][off];
      return 8'h00;
    end
    if (off >= 8'h60 && off < 8'h64) begin
      if (isFixed(d) && off == 8'h60) return FIXED[15:8];
      if (isFixed(d) && off == 8'h61) return FIXED[7:0];
      return sh[d][off];
    end
    if (off >= 8'h70 && off <= 8'h73) return (off % 2 == 0) ? (sh[d][off] & 8'h0F) : (sh[d][off] & 8'h03);
    if (off == 8'h74 || off == 8'h75) return sh[d][off] & 8'h07;
    return 8'h00;
  endfunction

  function automatic void modelWrite(input int d, input int off, input logic [7:0] v);
    if (off >= 8'h70 && off <= 8'h73 && off % 2 == 0) begin
      if (v[3:0] != 4'd2) sh[d][off] = {4'b0, v[3:0]};
    end else if (off == 8'h74 || off == 8'h75) begin
      if (v[2:0] <= 3'd4) sh[d][off] = {5'b0, v[2:0]};
    end else begin
      sh[d][off] = v;
    end
  endfunction

  task automatic readChk(input string tag, input int d, input int off);
    strobeOp(0, 8'(off));
    check($sformatf("%s dev%0d off %02h", tag, d, off), rdData, modelRead(d, off));
  endtask

  task automatic selDev(input int d);
    strobeOp(0, 8'h07);
    strobeOp(1, 8'(d));
    curLdn = d;
  endtask

  task automatic checkExports(input string tag);
    for (int d = 0; d < 2; d++) begin
      bit a = sh[d][8'h30][0];
      check({tag, " R10 active"}, devActive[d], a);
      for (int s = 0; s < 2; s++) begin
        int mi = d*2 + s;
        logic [15:0] ioE = (isFixed(d) && s == 0) ? FIXED : {sh[d][8'h60+2*s], sh[d][8'h61+2*s]};
        check({tag, " R10 memBase"}, memBaseOut[mi*16 +: 16], a ? {sh[d][8'h40+8*s], sh[d][8'h41+8*s]} : 16'h0);
        check({tag, " R10 memCtrl"}, memCtrlOut[mi*2 +: 2], a ? sh[d][8'h42+8*s][1:0] : 2'b0);
        check({tag, " R10 memLimit"}, memLimitOut[mi*16 +: 16], a ? {sh[d][8'h43+8*s], sh[d][8'h44+8*s]} : 16'h0);
        check({tag, " R10/R9 ioBase"}, ioBaseOut[mi*16 +: 16], a ? ioE : 16'h0);
        check({tag, " R10 irqLevel"}, irqLevelOut[mi*4 +: 4], a ? sh[d][8'h70+2*s][3:0] : 4'd0);
        check({tag, " R10 irqType"}, irqTypeOut[mi*2 +: 2], a ? sh[d][8'h71+2*s][1:0] : 2'd0);
        check({tag, " R10 dma"}, dmaSelOut[mi*3 +: 3], a ? sh[d][8'h74+s][2:0] : 3'd4);
      end
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    for (int d = 0; d < 2; d++)
      for (int o = 0; o < 128; o++) sh[d][o] = (o == 8'h74 || o == 8'h75) ? 8'h04 : 8'h00;

    #20;
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 devActive", devActive, 2'b00);
    check("R1 dma exports", dmaSelOut, {4{3'd4}});
    check("R1 rdData in wfk", rdData, 8'h00);

    // R2: wake ignored in wait-for-key; R3 write ignored there
    strobeOp(2, CSN);
    strobeOp(0, 8'h74);
    check("R2 wake ignored in wfk", rdData, 8'h00);
    strobeOp(0, 8'h60);
    strobeOp(1, 8'h55);
    strobeOp(3, 8'h00);
    strobeOp(0, 8'h74);
    check("R3 read zero in sleep", rdData, 8'h00);
    strobeOp(2, CSN);
    check("R2 wake match enters config", rdData, 8'h04);
    strobeOp(2, CSN + 8'h1);
    check("R2 wake mismatch sleeps", rdData, 8'h00);
    strobeOp(2, CSN);
    check("R2 rewake", rdData, 8'h04);

    // R1/R11/R9: full reset sweep of both banks (also proves the wfk write was dropped: R3)
    for (int d = 0; d < 2; d++) begin
      selDev(d);
      for (int o = 0; o < 128; o++) readChk("R1/R11 reset", d, o);
    end

    // R4: invalid device number ignored
    selDev(1);
    strobeOp(0, 8'h07);
    strobeOp(1, 8'h02);
    check("R4 ldn out of range ignored", rdData, 8'h01);

    // R5/R6/R9/R11 write sweep, then read back both banks
    for (int d = 0; d < 2; d++) begin
      selDev(d);
      for (int o = 8; o < 128; o++) begin
        logic [7:0] v = 8'((o * 37 + d * 91 + 3) & 8'hFF);
        strobeOp(0, 8'(o));
        strobeOp(1, v);
        modelWrite(d, o, v);
      end
    end
    for (int d = 0; d < 2; d++) begin
      selDev(d);
      for (int o = 0; o < 128; o++) readChk("R5/R6/R9/R11 sweep", d, o);
    end

    // R7: every interrupt level code, R8: every DMA code
    selDev(0);
    for (int v = 0; v < 16; v++) begin
      strobeOp(0, 8'h72);
      strobeOp(1, 8'(v));
      modelWrite(0, 8'h72, 8'(v));
      check($sformatf("R7 irq level write %0d", v), rdData, modelRead(0, 8'h72));
    end
    strobeOp(1, 8'h09);
    check("R7 level 9 stored", rdData, 8'h09);
    strobeOp(1, 8'h02);
    check("R7 level 2 ignored", rdData, 8'h09);
    modelWrite(0, 8'h72, 8'h09);
    for (int v = 0; v < 8; v++) begin
      strobeOp(0, 8'h75);
      strobeOp(1, 8'(v));
      modelWrite(0, 8'h75, 8'(v));
      check($sformatf("R8 dma write %0d", v), rdData, modelRead(0, 8'h75));
    end

    // R10 exports: device 0 active, device 1 inactive
    strobeOp(0, 8'h30);
    strobeOp(1, 8'h01);
    modelWrite(0, 8'h30, 8'h01);
    selDev(1);
    strobeOp(0, 8'h30);
    strobeOp(1, 8'h00);
    modelWrite(1, 8'h30, 8'h00);
    checkExports("one active");
    strobeOp(1, 8'h01);
    modelWrite(1, 8'h30, 8'h01);
    checkExports("both active");

    // R3: back to wait-for-key, writes have no effect
    strobeOp(4, 8'h00);
    strobeOp(0, 8'h30);
    strobeOp(1, 8'h00);
    check("R3 rdData zero in wfk", rdData, 8'h00);
    checkExports("after wfk write R3");
    strobeOp(3, 8'h00);
    strobeOp(2, CSN);
    readChk("R3 bank kept", 1, 8'h30);

    done = 1;
    summary();
    $finish;
  end

endmodule